// File: doc/BRIEF.md
# Oscillator Stabilization Wait Timer

This block keeps the system clock gated off after the chip leaves its low-power stop state. It waits until the crystal or ceramic oscillator has run for a chosen number of its own cycles, and then it raises `clk_ready`. Software picks one of four power-of-two wait lengths by writing a byte-wide select register, and only the two low bits of that register take effect. After a reset the wait length comes from a configuration-byte selection input instead, which uses the same two-bit encoding. When the clock source is the internal oscillator or an external clock input, the block applies no wait and declares the clock ready at once.

Counting begins only when the oscillator is reported as toggling (`osc_running`). Any time between the release event and the start of oscillation does not count toward the wait. The release may come from an interrupt or from a reset, and the wait is the same in both cases. The wait length is captured when the release happens, so a register write made during a wait only affects the next wait. The counter is as wide as the largest exponent, which is 17 bits with the default parameters. At 10 MHz the default settings give waits of about 0.1 ms, 0.4 ms, 3.3 ms and 13 ms.

Top module: `osc_wait_timer`

## Requirements
- R1: A write to the select register stores `reg_wr_data[1:0]` and discards bits 7:2. The read port `reg_rd_data` always shows zeros in bits 7:2 and the stored code in bits 1:0. The stored code is 00 after reset.
- R2: The wait code sets the wait length. Code 00 gives 2^WAIT_EXP0 cycles, 01 gives 2^WAIT_EXP1, 10 gives 2^WAIT_EXP2 and 11 gives 2^WAIT_EXP3. The default exponents are 10, 12, 15 and 17.
- R3: When the source is crystal or ceramic, `clk_ready` rises on the clock edge that comes 2^E edges after the edge at which `osc_running` is first sampled high following the wake-up. Edges before that point, while the oscillator is not yet running, do not count.
- R4: When `src_is_xtal` is low at a stop release, `clk_ready` is high right after that release edge. When `src_is_xtal` is low at the first edge after reset, `clk_ready` is high right after that edge.
- R5: After reset, and only when the source is crystal or ceramic, the wait uses the code on `por_sel` (same encoding as R2) and not the select register.
- R6: A `stop_enter` pulse, sampled while the block is not already stopped, makes `clk_ready` low after that edge. Once `clk_ready` is high, it stays high until the next stop entry.
- R7: A register write made during an active wait does not change the length of that wait. The new code applies from the next stop release.
- R8: A `stop_release` pulse has no effect unless the block is in the stopped state. For example, `clk_ready` stays high when a release arrives while the clock is already ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock that drives the wait counter |
| rst_n | input | 1 | Active-low reset; the block starts the power-on wait when reset is released |
| reg_wr_en | input | 1 | Write strobe for the select register |
| reg_wr_data | input | 8 | Write data; only bits 1:0 are kept |
| reg_rd_data | output | 8 | Select register read value; bits 7:2 are zero |
| stop_enter | input | 1 | Pulse that marks entry into the stop state |
| stop_release | input | 1 | Pulse that marks a stop release (from an interrupt or a reset) |
| osc_running | input | 1 | High once the oscillator is toggling |
| src_is_xtal | input | 1 | High when a crystal or ceramic oscillator is the system clock source |
| por_sel | input | 2 | Wait code from the configuration byte, used after reset |
| clk_ready | output | 1 | High when the system clock may be released |

## Verification
The wait length is measured edge by edge from the point where the oscillator starts. A design that also counted the idle gap after release, or that counted one edge too many or too few, would give a wrong count, and the bench inserts oscillator-start delays of several different lengths to expose this. The bench also rewrites the register in the middle of a wait. A design that reread the register live would end that wait early or late. Other tests cover a non-crystal source, which must skip the wait; the reset path, which must follow `por_sel` and not the register; stray releases while the clock is ready; and high junk bits in a register write, which must read back as zero.

// File: rtl/osc_wait_pkg.sv
package osc_wait_pkg;

  typedef enum logic [1:0] {
    ST_WAKE  = 2'd0,
    ST_COUNT = 2'd1,
    ST_READY = 2'd2,
    ST_STOP  = 2'd3
  } owt_state_e;

  // exponent chosen by a two-bit wait code
  function automatic int unsigned code_to_exp(input logic [1:0] code,
                                              input int unsigned e0,
                                              input int unsigned e1,
                                              input int unsigned e2,
                                              input int unsigned e3);
    case (code)
      2'd0:    return e0;
      2'd1:    return e1;
      2'd2:    return e2;
      default: return e3;
    endcase
  endfunction

  function automatic int unsigned max_of4(input int unsigned a,
                                          input int unsigned b,
                                          input int unsigned c,
                                          input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/owt_sel_reg.sv
module owt_sel_reg #(
  parameter int unsigned BUS_W  = 8,
  parameter int unsigned CODE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BUS_W-1:0]  wr_data,
  output logic [CODE_W-1:0] code,
  output logic [BUS_W-1:0]  rd_data
);

  localparam int unsigned PAD_W = BUS_W - CODE_W;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code <= '0;
    end else if (wr_en) begin
      code <= wr_data[CODE_W-1:0];
    end
  end

  assign rd_data = {{PAD_W{1'b0}}, code};

endmodule

// File: rtl/owt_counter.sv
module owt_counter #(
  parameter int unsigned CNT_W = 17,
  parameter int unsigned EXP0  = 10,
  parameter int unsigned EXP1  = 12,
  parameter int unsigned EXP2  = 15,
  parameter int unsigned EXP3  = 17
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       run,
  input  logic [1:0] code,
  output logic       done
);
  import osc_wait_pkg::*;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last_val;

  always_comb begin
    last_val = CNT_W'((64'd1 << code_to_exp(code, EXP0, EXP1, EXP2, EXP3)) - 64'd1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clear) begin
      cnt <= '0;
    end else if (run) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign done = run && (cnt == last_val);

endmodule

// File: rtl/owt_wait_ctrl.sv
module owt_wait_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stop_enter,
  input  logic       stop_release,
  input  logic       osc_running,
  input  logic       src_is_xtal,
  input  logic [1:0] reg_code,
  input  logic [1:0] por_code,
  input  logic       wait_done,
  output logic       wait_start,
  output logic       counting,
  output logic       in_stop,
  output logic       clk_ready,
  output logic [1:0] active_code
);
  import osc_wait_pkg::*;

  owt_state_e state, state_nxt;
  logic       use_por;
  logic [1:0] code_lat;

  assign in_stop    = (state == ST_STOP);
  assign counting   = (state == ST_COUNT);
  assign clk_ready  = (state == ST_READY);
  assign wait_start = (state == ST_WAKE) && !stop_enter && src_is_xtal && osc_running;

  always_comb begin
    state_nxt = state;
    case (state)
      ST_WAKE: begin
        if (stop_enter)        state_nxt = ST_STOP;
        else if (!src_is_xtal) state_nxt = ST_READY;
        else if (osc_running)  state_nxt = ST_COUNT;
      end
      ST_COUNT: begin
        if (stop_enter)     state_nxt = ST_STOP;
        else if (wait_done) state_nxt = ST_READY;
      end
      ST_READY: begin
        if (stop_enter) state_nxt = ST_STOP;
      end
      default: begin
        if (stop_release) state_nxt = src_is_xtal ? ST_WAKE : ST_READY;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_WAKE;
      use_por     <= 1'b1;
      code_lat    <= '0;
      active_code <= '0;
    end else begin
      state <= state_nxt;
      if (in_stop && stop_release) begin
        code_lat <= reg_code;
        use_por  <= 1'b0;
      end
      if (wait_start) begin
        active_code <= use_por ? por_code : code_lat;
      end
    end
  end

endmodule

// File: rtl/osc_wait_timer.sv
module osc_wait_timer #(
  parameter int unsigned WAIT_EXP0 = 10,
  parameter int unsigned WAIT_EXP1 = 12,
  parameter int unsigned WAIT_EXP2 = 15,
  parameter int unsigned WAIT_EXP3 = 17,
  parameter int unsigned BUS_W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr_en,
  input  logic [BUS_W-1:0] reg_wr_data,
  output logic [BUS_W-1:0] reg_rd_data,
  input  logic             stop_enter,
  input  logic             stop_release,
  input  logic             osc_running,
  input  logic             src_is_xtal,
  input  logic [1:0]       por_sel,
  output logic             clk_ready
);
  import osc_wait_pkg::*;

  localparam int unsigned CNT_W = max_of4(WAIT_EXP0, WAIT_EXP1, WAIT_EXP2, WAIT_EXP3);

  logic [1:0] reg_code;
  logic [1:0] active_code;
  logic       wait_start;
  logic       wait_done;
  logic       counting;
  logic       in_stop;

  owt_sel_reg #(.BUS_W(BUS_W), .CODE_W(2)) u_sel (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (reg_wr_en),
    .wr_data (reg_wr_data),
    .code    (reg_code),
    .rd_data (reg_rd_data)
  );

  owt_wait_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .stop_enter   (stop_enter),
    .stop_release (stop_release),
    .osc_running  (osc_running),
    .src_is_xtal  (src_is_xtal),
    .reg_code     (reg_code),
    .por_code     (por_sel),
    .wait_done    (wait_done),
    .wait_start   (wait_start),
    .counting     (counting),
    .in_stop      (in_stop),
    .clk_ready    (clk_ready),
    .active_code  (active_code)
  );

  owt_counter #(
    .CNT_W (CNT_W),
    .EXP0  (WAIT_EXP0),
    .EXP1  (WAIT_EXP1),
    .EXP2  (WAIT_EXP2),
    .EXP3  (WAIT_EXP3)
  ) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (wait_start),
    .run   (counting),
    .code  (active_code),
    .done  (wait_done)
  );

endmodule

// File: rtl/owt_checker.sv
module owt_checker #(
  parameter int unsigned BUS_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             stop_enter,
  input logic             stop_release,
  input logic             src_is_xtal,
  input logic             clk_ready,
  input logic [BUS_W-1:0] reg_rd_data,
  input logic             in_stop,
  input logic             counting,
  input logic             wait_done,
  input logic [1:0]       active_code
);

  p_rd_upper_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_data[BUS_W-1:2] == '0);

  p_done_gives_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_done && !stop_enter) |=> clk_ready);

  p_skip_no_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_stop && stop_release && !src_is_xtal) |=> clk_ready);

  p_stop_drops_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_enter && !in_stop) |=> !clk_ready);

  p_ready_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_ready && !stop_enter) |=> clk_ready);

  p_code_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (counting && $past(counting)) |-> $stable(active_code));

  p_release_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_ready && stop_release && !stop_enter) |=> clk_ready);

endmodule

bind osc_wait_timer owt_checker #(.BUS_W(BUS_W)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .stop_enter   (stop_enter),
  .stop_release (stop_release),
  .src_is_xtal  (src_is_xtal),
  .clk_ready    (clk_ready),
  .reg_rd_data  (reg_rd_data),
  .in_stop      (in_stop),
  .counting     (counting),
  .wait_done    (wait_done),
  .active_code  (active_code)
);

// File: tb/osc_wait_timer_tb_top.sv
module osc_wait_timer_tb_top;

  localparam int E0 = 4;
  localparam int E1 = 5;
  localparam int E2 = 7;
  localparam int E3 = 9;
  localparam int NV = 6;
  localparam logic [7:0] V_WDATA [NV] = '{8'h00, 8'hFD, 8'h06, 8'hA7, 8'h01, 8'hFE};
  localparam logic [7:0] V_RD    [NV] = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h01, 8'h02};
  localparam int         V_DLY   [NV] = '{0, 3, 0, 5, 9, 1};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr_en = 1'b0;
  logic [7:0] reg_wr_data = '0;
  logic [7:0] reg_rd_data;
  logic       stop_enter = 1'b0;
  logic       stop_release = 1'b0;
  logic       osc_running = 1'b0;
  logic       src_is_xtal = 1'b1;
  logic [1:0] por_sel = 2'd0;
  logic       clk_ready;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  osc_wait_timer #(
    .WAIT_EXP0(E0), .WAIT_EXP1(E1), .WAIT_EXP2(E2), .WAIT_EXP3(E3)
  ) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_wr_en    (reg_wr_en),
    .reg_wr_data  (reg_wr_data),
    .reg_rd_data  (reg_rd_data),
    .stop_enter   (stop_enter),
    .stop_release (stop_release),
    .osc_running  (osc_running),
    .src_is_xtal  (src_is_xtal),
    .por_sel      (por_sel),
    .clk_ready    (clk_ready)
  );

  function automatic int wait_len(input logic [1:0] c);
    int e;
    e = (c == 2'd0) ? E0 : (c == 2'd1) ? E1 : (c == 2'd2) ? E2 : E3;
    return 1 << e;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_reg(input logic [7:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1;
    reg_wr_data = d;
    @(posedge clk);
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  // counts edges from the one that first sees osc_running high until clk_ready
  task automatic measure(input int expn, input string req, input int wr_at, input logic [7:0] wr_val);
    int n = 0;
    bit seen = 1'b0;
    for (int i = 0; i < expn + 8; i++) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      reg_wr_en = (n == wr_at);
      reg_wr_data = wr_val;
      if (clk_ready) begin
        seen = 1'b1;
        break;
      end
    end
    reg_wr_en = 1'b0;
    check(seen && n == expn, req, n, expn);
  endtask

  task automatic stop_cycle(input bit xtal, input int dly, input int expn, input string req,
                            input int wr_at, input logic [7:0] wr_val);
    @(negedge clk);
    stop_enter = 1'b1;
    osc_running = 1'b0;
    @(posedge clk);
    @(negedge clk);
    stop_enter = 1'b0;
    check(clk_ready == 1'b0, "R6 stop entry drops ready", clk_ready, 0);
    stop_release = 1'b1;
    src_is_xtal = xtal;
    @(posedge clk);
    @(negedge clk);
    stop_release = 1'b0;
    if (!xtal) begin
      check(clk_ready == 1'b1, "R4 non-crystal source skips wait", clk_ready, 1);
    end else begin
      for (int i = 0; i < dly; i++) begin
        @(posedge clk);
        @(negedge clk);
      end
      check(clk_ready == 1'b0, "R3 no ready before oscillation", clk_ready, 0);
      osc_running = 1'b1;
      measure(expn, req, wr_at, wr_val);
    end
  endtask

  task automatic do_reset(input logic [1:0] por, input bit xtal);
    @(negedge clk);
    rst_n = 1'b0;
    por_sel = por;
    src_is_xtal = xtal;
    osc_running = 1'b1;
    repeat (3) @(negedge clk);
    check(reg_rd_data == 8'h00, "R1 reset value of select register", reg_rd_data, 0);
    check(clk_ready == 1'b0, "R5 not ready in reset", clk_ready, 0);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R5: reset wait follows por_sel, register holds 00
    do_reset(2'd2, 1'b1);
    measure(wait_len(2'd2) + 1, "R5 reset wait uses por_sel", 0, 8'h00);

    // R2/R3/R1: table of register codes and oscillator start delays
    for (int v = 0; v < NV; v++) begin
      write_reg(V_WDATA[v]);
      check(reg_rd_data == V_RD[v], "R1 readback masks upper bits", reg_rd_data, V_RD[v]);
      stop_cycle(1'b1, V_DLY[v], wait_len(V_RD[v][1:0]) + 1, "R2 R3 wait length", 0, 8'h00);
    end

    // R6: ready held for a while without stop entry
    repeat (20) @(negedge clk);
    check(clk_ready == 1'b1, "R6 ready held", clk_ready, 1);

    // R8: stray release while ready
    @(negedge clk);
    stop_release = 1'b1;
    @(posedge clk);
    @(negedge clk);
    stop_release = 1'b0;
    check(clk_ready == 1'b1, "R8 release ignored when ready", clk_ready, 1);
    repeat (3) @(negedge clk);
    check(clk_ready == 1'b1, "R8 still ready later", clk_ready, 1);

    // R7: write code 11 during a code-00 wait
    write_reg(8'h00);
    stop_cycle(1'b1, 2, wait_len(2'd0) + 1, "R7 mid-wait write ignored", 5, 8'h03);
    check(reg_rd_data == 8'h03, "R7 write stored", reg_rd_data, 3);
    stop_cycle(1'b1, 0, wait_len(2'd3) + 1, "R7 new code at next release", 0, 8'h00);

    // R4: non-crystal source after stop and after reset
    stop_cycle(1'b0, 0, 0, "R4 skip", 0, 8'h00);
    do_reset(2'd3, 1'b0);
    @(posedge clk);
    @(negedge clk);
    check(clk_ready == 1'b1, "R4 reset with non-crystal source ready at once", clk_ready, 1);

    // R5: register not consulted after reset
    write_reg(8'h03);
    do_reset(2'd1, 1'b1);
    measure(wait_len(2'd1) + 1, "R5 reset wait ignores register", 0, 8'h00);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule